// File: doc/BRIEF.md
# Line-Stride Read Address Generator

This block turns the payload fields of one DMA descriptor into a series of memory read requests. A single-cycle start pulse captures the transfer size, a packed line word (line length plus line pitch), a mode flag, a 12-bit high-address extension and up to five fragment base addresses. The block then issues one `(address, length)` request at a time over a valid/ready stream. When the series ends it raises a one-cycle done pulse. A memory error reported during the series ends it early, and the done pulse then carries an abort flag.

There are two modes. In line mode the block walks a rectangle. Each request reads one line. The address then moves on by the pitch, and the block repeats until the byte count is used up. In scatter mode each request reads from one fragment base up to the end of its 4 KiB page. The next request moves to the next fragment base, and the block stops after the fifth fragment even if bytes remain.

Back-pressure rules: the request stream is the only flow-controlled interface. `req_valid_o` is raised by the block and is not withdrawn until a transfer takes place (`req_valid_o && req_ready_i` at a rising edge) or the series is aborted. While it is raised, `req_addr_o` and `req_len_o` do not change. The consumer may hold `req_ready_i` low for any number of cycles. The start, error, done and busy pins are plain level/pulse controls with no handshake.

Top module: `stride_addr_gen`

## Requirements
- R1: After reset `req_valid_o`, `done_o`, `aborted_o` and `busy_o` are all low.
- R2: The packed line word holds the line length in bits [17:0] and the pitch in units of 16 bytes in bits [31:18]. In line mode (`scatter_i` = 0) each request has the line length, and each accepted request advances the next address by pitch × 16.
- R3: In line mode the series starts at the fragment-0 address and continues until the remaining byte count reaches zero. The final request is shortened to the remaining count when that count is below the line length.
- R4: The fragment-0 address is base 0 plus `page_ext_i` shifted left by 20. Bases 1 to 4 are used as given.
- R5: In scatter mode (`scatter_i` = 1), request k reads from fragment address k. Its length is 4096 minus (address mod 4096), shortened to the remaining byte count when that count is smaller.
- R6: In scatter mode at most five requests are issued. The series ends after the fifth even if bytes remain.
- R7: While `req_valid_o` is high and the request is not accepted, the request stays valid with the same address and length in the next cycle.
- R8: `done_o` is high for exactly one cycle, the cycle after the final request is accepted, with `aborted_o` low. `busy_o` is high from the cycle after the start pulse until and including the done cycle.
- R9: A transfer size of zero, or a line length of zero in line mode, produces no request, and `done_o` is high in the cycle after the start pulse.
- R10: `rd_err_i` high while a request is valid ends the series. No further request is issued, and `done_o` and `aborted_o` are high together in the next cycle. This holds even when `req_ready_i` is high in the same cycle.
- R11: A start pulse while `busy_o` is high is ignored and does not disturb the series in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Capture descriptor fields and begin a series |
| scatter_i | input | 1 | 0 = line mode, 1 = scatter mode |
| xfer_size_i | input | SIZE_W | Total bytes to request |
| line_word_i | input | 32 | Packed line length [17:0] and pitch/16 [31:18] |
| page_ext_i | input | 12 | High-address extension added to base 0 at bit 20 |
| frag_base_i | input | NFRAG*ADDR_W | Fragment base k at bits [k*ADDR_W +: ADDR_W] |
| req_valid_o | output | 1 | Read request valid |
| req_ready_i | input | 1 | Consumer accepts the request |
| req_addr_o | output | ADDR_W | Request byte address |
| req_len_o | output | LEN_W | Request byte length |
| rd_err_i | input | 1 | Memory read error; aborts the series |
| busy_o | output | 1 | Series in progress |
| done_o | output | 1 | One-cycle end-of-series pulse |
| aborted_o | output | 1 | High with `done_o` when the series ended on an error |

## Verification
A read error and a request acceptance can meet in the same cycle. The bench provokes this by raising `rd_err_i` and `req_ready_i` together on a chosen request. It judges that the error wins: the next cycle shows `done_o` with `aborted_o` and no further valid request. A second case raises the error while the consumer is stalling, to show that the abort does not wait for acceptance. A start pulse arriving during a live series is also injected, and the bench checks that the request sequence and the final done match the first descriptor alone.

// File: rtl/sag_pkg.sv
package sag_pkg;

  localparam int unsigned PAGE_BYTES   = 4096;
  localparam int unsigned PAGE_W       = 12;
  localparam int unsigned LINE_W       = 18;
  localparam int unsigned PITCH_LSB    = 18;
  localparam int unsigned PITCH_W      = 14;
  localparam int unsigned PITCH_SCALE  = 4;
  localparam int unsigned EXT_W        = 12;
  localparam int unsigned EXT_SHIFT    = 20;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_DONE  = 2'd2
  } seq_state_e;

  function automatic logic [LINE_W-1:0] line_len_of(input logic [31:0] word);
    return word[LINE_W-1:0];
  endfunction

  function automatic logic [PITCH_W+PITCH_SCALE-1:0] pitch_of(input logic [31:0] word);
    return {word[PITCH_LSB +: PITCH_W], {PITCH_SCALE{1'b0}}};
  endfunction

endpackage

// File: rtl/sag_frag_addr.sv
module sag_frag_addr
  import sag_pkg::*;
#(
  parameter int unsigned ADDR_W = 48,
  parameter int unsigned NFRAG  = 5
) (
  input  logic [EXT_W-1:0]        ext_i,
  input  logic [NFRAG*ADDR_W-1:0] base_i,
  output logic [NFRAG*ADDR_W-1:0] addr_o
);

  localparam int unsigned EXT_TOP = EXT_SHIFT + EXT_W;

  for (genvar k = 0; k < NFRAG; k++) begin : g_frag
    if (k == 0) begin : g_ext
      logic [ADDR_W-1:0] ext_off;
      assign ext_off = {{(ADDR_W-EXT_TOP){1'b0}}, ext_i, {EXT_SHIFT{1'b0}}};
      assign addr_o[k*ADDR_W +: ADDR_W] = base_i[k*ADDR_W +: ADDR_W] + ext_off;
    end else begin : g_plain
      assign addr_o[k*ADDR_W +: ADDR_W] = base_i[k*ADDR_W +: ADDR_W];
    end
  end

endmodule

// File: rtl/sag_len_calc.sv
module sag_len_calc
  import sag_pkg::*;
#(
  parameter int unsigned ADDR_W = 48,
  parameter int unsigned SIZE_W = 32,
  parameter int unsigned LEN_W  = 18
) (
  input  logic              scatter_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [SIZE_W-1:0] rem_i,
  input  logic [LINE_W-1:0] line_i,
  output logic [LEN_W-1:0]  len_o,
  output logic [SIZE_W-1:0] rem_next_o
);

  logic [PAGE_W:0]   page_left;
  logic [SIZE_W-1:0] cand;
  logic [SIZE_W-1:0] len_w;

  assign page_left = (PAGE_W+1)'(PAGE_BYTES) - {1'b0, addr_i[PAGE_W-1:0]};

  always_comb begin
    if (scatter_i) cand = SIZE_W'(page_left);
    else           cand = SIZE_W'(line_i);
    len_w = (rem_i < cand) ? rem_i : cand;
  end

  assign len_o      = len_w[LEN_W-1:0];
  assign rem_next_o = rem_i - len_w;

endmodule

// File: rtl/sag_seq.sv
module sag_seq
  import sag_pkg::*;
#(
  parameter int unsigned ADDR_W = 48,
  parameter int unsigned SIZE_W = 32,
  parameter int unsigned LEN_W  = 18,
  parameter int unsigned NFRAG  = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic                    scatter_i,
  input  logic [SIZE_W-1:0]       size_i,
  input  logic [31:0]             line_word_i,
  input  logic [NFRAG*ADDR_W-1:0] frag_addr_i,
  input  logic [LEN_W-1:0]        calc_len_i,
  input  logic [SIZE_W-1:0]       calc_rem_i,
  output logic                    cur_scatter_o,
  output logic [ADDR_W-1:0]       cur_addr_o,
  output logic [SIZE_W-1:0]       cur_rem_o,
  output logic [LINE_W-1:0]       cur_line_o,
  output logic                    req_valid_o,
  input  logic                    req_ready_i,
  output logic [ADDR_W-1:0]       req_addr_o,
  output logic [LEN_W-1:0]        req_len_o,
  input  logic                    rd_err_i,
  output logic                    busy_o,
  output logic                    done_o,
  output logic                    aborted_o
);

  localparam int unsigned IDX_W = $clog2(NFRAG + 1);
  localparam int unsigned STR_W = PITCH_W + PITCH_SCALE;

  seq_state_e        state_q;
  logic [SIZE_W-1:0] rem_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LINE_W-1:0] line_q;
  logic [STR_W-1:0]  pitch_q;
  logic              scat_q;
  logic              abort_q;
  logic [IDX_W-1:0]  idx_q;
  logic [ADDR_W-1:0] frag_q [NFRAG];

  logic fire, err_hit, last_req, empty_start;
  logic [IDX_W-1:0] idx_nx;
  logic [ADDR_W-1:0] next_frag;

  assign fire     = (state_q == ST_ISSUE) && req_ready_i && !rd_err_i;
  assign err_hit  = (state_q == ST_ISSUE) && rd_err_i;
  assign idx_nx   = idx_q + IDX_W'(1);
  assign last_req = (calc_rem_i == '0) ||
                    (scat_q && (idx_q == IDX_W'(NFRAG - 1)));
  assign empty_start = (size_i == '0) ||
                       (!scatter_i && (line_len_of(line_word_i) == '0));

  always_comb begin
    next_frag = addr_q;
    for (int k = 1; k < NFRAG; k++) begin
      if (idx_nx == IDX_W'(k)) next_frag = frag_q[k];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rem_q   <= '0;
      addr_q  <= '0;
      line_q  <= '0;
      pitch_q <= '0;
      scat_q  <= 1'b0;
      abort_q <= 1'b0;
      idx_q   <= '0;
      for (int k = 0; k < NFRAG; k++) frag_q[k] <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            rem_q   <= size_i;
            line_q  <= line_len_of(line_word_i);
            pitch_q <= pitch_of(line_word_i);
            scat_q  <= scatter_i;
            abort_q <= 1'b0;
            idx_q   <= '0;
            addr_q  <= frag_addr_i[0 +: ADDR_W];
            for (int k = 0; k < NFRAG; k++) frag_q[k] <= frag_addr_i[k*ADDR_W +: ADDR_W];
            state_q <= empty_start ? ST_DONE : ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          if (err_hit) begin
            abort_q <= 1'b1;
            state_q <= ST_DONE;
          end else if (fire) begin
            rem_q <= calc_rem_i;
            idx_q <= idx_nx;
            if (scat_q) addr_q <= next_frag;
            else        addr_q <= addr_q + ADDR_W'(pitch_q);
            if (last_req) state_q <= ST_DONE;
          end
        end
        ST_DONE: begin
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cur_scatter_o = scat_q;
  assign cur_addr_o    = addr_q;
  assign cur_rem_o     = rem_q;
  assign cur_line_o    = line_q;

  assign req_valid_o = (state_q == ST_ISSUE);
  assign req_addr_o  = addr_q;
  assign req_len_o   = calc_len_i;
  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = (state_q == ST_DONE);
  assign aborted_o   = (state_q == ST_DONE) && abort_q;

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && !req_ready_i && !rd_err_i) |=>
      (req_valid_o && $stable(req_addr_o) && $stable(req_len_o)));

  p_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && rd_err_i) |=> (done_o && aborted_o && !req_valid_o));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_len_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o |-> (req_len_o != '0));

  p_page_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && scat_q) |->
      ((32'(req_addr_o[PAGE_W-1:0]) + 32'(req_len_o)) <= 32'(PAGE_BYTES)));

  p_frag_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && scat_q) |-> (idx_q < IDX_W'(NFRAG)));

  p_busy_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && start_i && !req_ready_i && !rd_err_i) |=>
      $stable(cur_rem_o));

endmodule

// File: rtl/stride_addr_gen.sv
module stride_addr_gen
  import sag_pkg::*;
#(
  parameter int unsigned ADDR_W = 48,
  parameter int unsigned SIZE_W = 32,
  parameter int unsigned NFRAG  = 5,
  localparam int unsigned LEN_W = (LINE_W > PAGE_W + 1) ? LINE_W : PAGE_W + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic                    scatter_i,
  input  logic [SIZE_W-1:0]       xfer_size_i,
  input  logic [31:0]             line_word_i,
  input  logic [EXT_W-1:0]        page_ext_i,
  input  logic [NFRAG*ADDR_W-1:0] frag_base_i,
  output logic                    req_valid_o,
  input  logic                    req_ready_i,
  output logic [ADDR_W-1:0]       req_addr_o,
  output logic [LEN_W-1:0]        req_len_o,
  input  logic                    rd_err_i,
  output logic                    busy_o,
  output logic                    done_o,
  output logic                    aborted_o
);

  logic [NFRAG*ADDR_W-1:0] frag_addr;
  logic                    cur_scatter;
  logic [ADDR_W-1:0]       cur_addr;
  logic [SIZE_W-1:0]       cur_rem;
  logic [LINE_W-1:0]       cur_line;
  logic [LEN_W-1:0]        calc_len;
  logic [SIZE_W-1:0]       calc_rem;

  sag_frag_addr #(.ADDR_W(ADDR_W), .NFRAG(NFRAG)) u_frag (
    .ext_i  (page_ext_i),
    .base_i (frag_base_i),
    .addr_o (frag_addr)
  );

  sag_len_calc #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .LEN_W(LEN_W)) u_len (
    .scatter_i  (cur_scatter),
    .addr_i     (cur_addr),
    .rem_i      (cur_rem),
    .line_i     (cur_line),
    .len_o      (calc_len),
    .rem_next_o (calc_rem)
  );

  sag_seq #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .LEN_W(LEN_W), .NFRAG(NFRAG)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .scatter_i     (scatter_i),
    .size_i        (xfer_size_i),
    .line_word_i   (line_word_i),
    .frag_addr_i   (frag_addr),
    .calc_len_i    (calc_len),
    .calc_rem_i    (calc_rem),
    .cur_scatter_o (cur_scatter),
    .cur_addr_o    (cur_addr),
    .cur_rem_o     (cur_rem),
    .cur_line_o    (cur_line),
    .req_valid_o   (req_valid_o),
    .req_ready_i   (req_ready_i),
    .req_addr_o    (req_addr_o),
    .req_len_o     (req_len_o),
    .rd_err_i      (rd_err_i),
    .busy_o        (busy_o),
    .done_o        (done_o),
    .aborted_o     (aborted_o)
  );

endmodule

// File: tb/stride_addr_gen_tb_top.sv
module stride_addr_gen_tb_top;

  localparam int ADDR_W = 48;
  localparam int SIZE_W = 32;
  localparam int NFRAG  = 5;
  localparam int LEN_W  = 18;

  typedef struct packed {
    logic        scat;
    logic [31:0] size;
    logic [31:0] lw;
    logic [11:0] ext;
    logic [47:0] b0, b1, b2, b3, b4;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 32'd100,   (32'd3 << 18) | 32'd32,         12'h005,
      48'h0000_1000_0000, 48'h0, 48'h0, 48'h0, 48'h0},
    '{1'b0, 32'd64,    (32'd1 << 18) | 32'd16,         12'h000,
      48'h0000_0000_4000, 48'h0, 48'h0, 48'h0, 48'h0},
    '{1'b1, 32'd10000, 32'd0,                          12'h001,
      48'h0000_2000_0F00, 48'h0000_3000_0000, 48'h0000_4000_0800,
      48'h0000_5000_0010, 48'h0000_6000_0000},
    '{1'b1, 32'd100000, 32'd0,                         12'h000,
      48'h0001_0000_0000, 48'h0001_0000_1100, 48'h0001_0000_2F00,
      48'h0001_0000_3000, 48'h0001_0000_4FF0},
    '{1'b1, 32'd100,   32'd0,                          12'h000,
      48'h0000_0007_0000, 48'h0, 48'h0, 48'h0, 48'h0},
    '{1'b0, 32'h50000, (32'h3FFF << 18) | 32'h3FFFF,   12'hFFF,
      48'h00AB_0000_0000, 48'h0, 48'h0, 48'h0, 48'h0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic scatter_i = 1'b0;
  logic [SIZE_W-1:0] xfer_size_i = '0;
  logic [31:0] line_word_i = '0;
  logic [11:0] page_ext_i = '0;
  logic [NFRAG*ADDR_W-1:0] frag_base_i = '0;
  logic req_ready_i = 1'b0;
  logic rd_err_i = 1'b0;
  logic req_valid_o, busy_o, done_o, aborted_o;
  logic [ADDR_W-1:0] req_addr_o;
  logic [LEN_W-1:0] req_len_o;

  always #10 clk = ~clk;

  stride_addr_gen dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .scatter_i(scatter_i),
    .xfer_size_i(xfer_size_i), .line_word_i(line_word_i), .page_ext_i(page_ext_i),
    .frag_base_i(frag_base_i), .req_valid_o(req_valid_o), .req_ready_i(req_ready_i),
    .req_addr_o(req_addr_o), .req_len_o(req_len_o), .rd_err_i(rd_err_i),
    .busy_o(busy_o), .done_o(done_o), .aborted_o(aborted_o)
  );

  int checks = 0;
  int failures = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  vec_t cfg;

  task automatic load_cfg(input vec_t v);
    cfg = v;
    scatter_i   = v.scat;
    xfer_size_i = v.size;
    line_word_i = v.lw;
    page_ext_i  = v.ext;
    frag_base_i = {v.b4, v.b3, v.b2, v.b1, v.b0};
  endtask

  // err_at: request number that sees rd_err_i (-1 none); err_stall: raise it with ready low
  task automatic run_case(input int err_at, input bit err_stall, input bit mid_start,
                          input string tag);
    logic [47:0] base [NFRAG];
    logic [47:0] m_addr;
    logic [31:0] m_rem, line, pitch, m_len, cand;
    int idx, nreq, cyc;
    bit m_done, exp_abort, stalled;
    logic [47:0] st_addr;
    logic [31:0] st_len;
    base[0] = cfg.b0 + ({36'd0, cfg.ext} << 20);  // R4
    base[1] = cfg.b1; base[2] = cfg.b2; base[3] = cfg.b3; base[4] = cfg.b4;
    line  = {14'd0, cfg.lw[17:0]};
    pitch = {14'd0, cfg.lw[31:18]} * 32'd16;
    m_addr = base[0]; m_rem = cfg.size; idx = 0; nreq = 0;
    m_done = (cfg.size == 0) || (!cfg.scat && line == 0);
    exp_abort = 1'b0; stalled = 1'b0; st_addr = '0; st_len = '0;
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    cyc = 0;
    forever begin
      req_ready_i = 1'b0;
      rd_err_i = 1'b0;
      if (mid_start) start_i = (cyc == 1);
      if (m_done) begin
        chk(done_o === 1'b1, {tag, " R8 done after last"}, done_o, 1);
        chk(aborted_o === exp_abort, {tag, " R10 abort flag"}, aborted_o, exp_abort);
        chk(req_valid_o === 1'b0, {tag, " R10 no request at done"}, req_valid_o, 0);
        break;
      end
      chk(done_o === 1'b0, {tag, " R8 no early done"}, done_o, 0);
      if (cfg.scat) cand = 32'd4096 - {20'd0, m_addr[11:0]};
      else          cand = line;
      m_len = (m_rem < cand) ? m_rem : cand;
      chk(req_valid_o === 1'b1, {tag, " R3 request valid"}, req_valid_o, 1);
      chk(req_addr_o === m_addr, cfg.scat ? {tag, " R5 address"} : {tag, " R2 address"},
          req_addr_o, m_addr);
      chk(32'(req_len_o) === m_len, cfg.scat ? {tag, " R5 length"} : {tag, " R3 length"},
          req_len_o, m_len);
      if (stalled)
        chk(req_addr_o === st_addr && 32'(req_len_o) === st_len, {tag, " R7 held"},
            req_addr_o, st_addr);
      if (nreq == err_at) begin
        rd_err_i = 1'b1;
        req_ready_i = !err_stall;
        m_done = 1'b1;
        exp_abort = 1'b1;
      end else begin
        req_ready_i = (cyc % 3) != 2;
        stalled = !req_ready_i;
        st_addr = req_addr_o;
        st_len = 32'(req_len_o);
        if (req_ready_i) begin
          nreq++;
          m_rem = m_rem - m_len;
          if (cfg.scat) begin
            idx++;
            if (m_rem == 0 || idx == NFRAG) m_done = 1'b1;  // R6
            else m_addr = base[idx];
          end else begin
            m_addr = m_addr + {16'd0, pitch};
            if (m_rem == 0) m_done = 1'b1;
          end
        end
      end
      @(negedge clk);
      cyc++;
      if (cyc > 3000) begin
        chk(1'b0, {tag, " R8 series ended"}, 0, 1);
        break;
      end
    end
    start_i = 1'b0;
    req_ready_i = 1'b0;
    rd_err_i = 1'b0;
    @(negedge clk);
    chk(busy_o === 1'b0 && req_valid_o === 1'b0, {tag, " R11 idle after done"},
        {busy_o, req_valid_o}, 0);
    if (cfg.scat && err_at < 0 && cfg.size > 20000)
      chk(nreq == NFRAG, {tag, " R6 five fragments"}, nreq, NFRAG);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_valid_o === 0 && done_o === 0 && aborted_o === 0 && busy_o === 0,
        "R1 reset state", {req_valid_o, done_o, aborted_o, busy_o}, 0);

    for (int v = 0; v < NVEC; v++) begin
      load_cfg(VECS[v]);
      run_case(-1, 1'b0, 1'b0, $sformatf("vec%0d", v));
    end

    // R9 zero size
    load_cfg(VECS[0]);
    xfer_size_i = '0; cfg.size = '0;
    run_case(-1, 1'b0, 1'b0, "R9 zero size");
    // R9 zero line length in line mode
    load_cfg(VECS[1]);
    line_word_i = 32'd1 << 18; cfg.lw = line_word_i;
    run_case(-1, 1'b0, 1'b0, "R9 zero line");
    // R10 error with ready in same cycle
    load_cfg(VECS[0]);
    run_case(1, 1'b0, 1'b0, "R10 err+ready");
    // R10 error while stalled, scatter mode
    load_cfg(VECS[2]);
    run_case(0, 1'b1, 1'b0, "R10 err stalled");
    // R11 start pulse during series
    load_cfg(VECS[1]);
    run_case(-1, 1'b0, 1'b1, "R11 mid start");
    // rd_err in idle has no effect on the next series
    rd_err_i = 1'b1;
    @(negedge clk);
    rd_err_i = 1'b0;
    chk(done_o === 0 && busy_o === 0, "R10 idle error ignored", {done_o, busy_o}, 0);
    load_cfg(VECS[4]);
    run_case(-1, 1'b0, 1'b0, "R5 after idle error");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule